// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small microcontroller sequencer. When the sequencer takes a subroutine call or branches to an interrupt vector, it pulses the push strobe and presents the current program counter. The block stores that value on top of the stack. Return-type instructions pulse the pop strobe. The block then shows the most recently saved address on its output and removes it from the stack.

The stack is a ring of eight 13-bit slots with a hidden pointer that wraps modulo the depth. Pushing past eight entries overwrites the oldest ones. Popping more than was pushed reads back whatever older word the slot still holds. The block reports no overflow or underflow, and the pointer cannot be read or written. The stack does not touch the program-counter page latch or any other register outside itself.

Top module: `ret_addr_stack`

## Requirements
- R1: Depth (default 8) and entry width (default 13) are parameters. The pointer is log2(depth) bits wide and wraps modulo the depth with no status output.
- R2: Reset (rst_ni low, asynchronous) returns the pointer to slot 0 and leaves stored words unchanged. The first push after reset therefore lands in slot 0, and the word shown on the output right after reset is the content of slot depth-1.
- R3: pop_addr_o continuously shows the entry below the pointer, which is the top of the stack. A push in cycle t makes pop_addr_o equal that cycle's push_addr_i from cycle t+1 on.
- R4: A pop (pop_i high, push_i low) consumes the value shown on pop_addr_o in that same cycle and moves the pointer down by one. Values come back in reverse order of pushing.
- R5: After N more than depth consecutive pushes, the push numbered depth+k overwrites the word from push k. Later pops return the newest depth values and then continue around the ring.
- R6: A pop from an empty stack still moves the pointer down modulo the depth and returns the word held in that slot.
- R7: When push_i and pop_i are high in the same cycle, only the push takes effect.
- R8: With both strobes low, the pointer and pop_addr_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the pointer |
| push_i | input | 1 | Save push_addr_i on top of the stack |
| push_addr_i | input | WIDTH | Return address to save |
| pop_i | input | 1 | Remove the top entry |
| pop_addr_o | output | WIDTH | Current top-of-stack word |

## Verification
The assertions check four rules on every cycle: the pointer moves up by one on a push and down by one on a lone pop, wrapping in both cases; a pushed word is on the output the next cycle; a push followed at once by a pop restores the earlier top; and an idle cycle changes nothing. Only the bench's scenarios show the deeper ordering behaviour. That includes the full LIFO sequences at every fill level, overwriting of the oldest entry after nine and ten pushes, underflow reads of stale slots, and the fact that reset keeps the stored contents.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned RAS_DEPTH = 8;
  localparam int unsigned RAS_WIDTH = 13;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } ras_op_e;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = RAS_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output ras_op_e       op_o,
  output logic [AW-1:0] wr_idx_o,
  output logic [AW-1:0] top_idx_o
);
  logic [AW-1:0] ptr_q, ptr_d;

  // push wins over pop
  always_comb begin
    if (push_i)     op_o = OP_PUSH;
    else if (pop_i) op_o = OP_POP;
    else            op_o = OP_IDLE;
  end

  always_comb begin
    unique case (op_o)
      OP_PUSH: ptr_d = ptr_q + AW'(1);
      OP_POP:  ptr_d = ptr_q - AW'(1);
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign wr_idx_o  = ptr_q;
  assign top_idx_o = ptr_q - AW'(1);
endmodule

// File: rtl/ras_store.sv
module ras_store
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = RAS_DEPTH,
  parameter int unsigned WIDTH = RAS_WIDTH,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // contents survive reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = RAS_DEPTH,
  parameter int unsigned WIDTH = RAS_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_addr_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_addr_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  ras_op_e       op;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] top_idx;

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .op_o      (op),
    .wr_idx_o  (ptr_q),
    .top_idx_o (top_idx)
  );

  ras_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .we_i      (op == OP_PUSH),
    .wr_idx_i  (ptr_q),
    .wr_data_i (push_addr_i),
    .rd_idx_i  (top_idx),
    .rd_data_o (pop_addr_o)
  );
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 13,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic [WIDTH-1:0] push_addr_i,
  input logic             pop_i,
  input logic [WIDTH-1:0] pop_addr_o,
  input logic [AW-1:0]    ptr_q
);
  logic [1:0] live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;
  end

  AST_PTR_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> ptr_q == AW'($past(ptr_q) + AW'(1))); // R5
  AST_PTR_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ptr_q == AW'($past(ptr_q) - AW'(1))); // R6
  AST_PUSH_ON_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> pop_addr_o == $past(push_addr_i)); // R3
  AST_PUSH_POP_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd3 && $past(push_i) && pop_i && !push_i)
      |=> pop_addr_o == $past(pop_addr_o, 2)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> ($stable(ptr_q) && $stable(pop_addr_o))); // R8
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/ret_addr_stack_bench.sv
module ret_addr_stack_bench;
  localparam int DEPTH = 8;
  localparam int WIDTH = 13;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             push_i = 1'b0;
  logic             pop_i = 1'b0;
  logic [WIDTH-1:0] push_addr_i = '0;
  logic [WIDTH-1:0] pop_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model from the requirements
  logic [WIDTH-1:0] m_mem [DEPTH];
  logic [2:0]       m_ptr = '0;
  int               seq = 0;

  always #4 clk_i = ~clk_i;

  ret_addr_stack u_ret_addr_stack (.*);

  function automatic logic [WIDTH-1:0] val(int i);
    return WIDTH'((i * 613 + 1029) & 13'h1fff);
  endfunction

  task automatic chk(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational top before the edge
  task automatic cyc(bit p, bit q, string req);
    logic [WIDTH-1:0] d;
    @(negedge clk_i);
    d = val(seq);
    seq++;
    push_i = p; pop_i = q; push_addr_i = d;
    #1;
    if (q && !p) chk(req, pop_addr_o, m_mem[m_ptr - 3'd1]);
    if (p) begin m_mem[m_ptr] = d; m_ptr = m_ptr + 3'd1; end
    else if (q) m_ptr = m_ptr - 3'd1;
    @(posedge clk_i);
    #1;
    push_i = 1'b0; pop_i = 1'b0;
    if (p) chk({req, "/R3"}, pop_addr_o, d);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_ptr = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    logic [WIDTH-1:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // fill every slot once so the model matches the array
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, "R2");
    do_reset();
    #1 chk("R2 top after reset is last slot", pop_addr_o, m_mem[DEPTH-1]);
    cyc(1, 0, "R2");
    cyc(0, 1, "R2 first push in slot 0");
    // LIFO at every fill level
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) cyc(1, 0, "R1");
      for (int i = 0; i < n; i++) cyc(0, 1, "R4");
    end
    // wrap with 9 and 10 pushes, then pop around the ring
    for (int n = DEPTH + 1; n <= DEPTH + 2; n++) begin
      do_reset();
      for (int i = 0; i < n; i++) cyc(1, 0, "R5");
      for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1, "R5");
    end
    // underflow from empty
    do_reset();
    for (int i = 0; i < 3 * DEPTH; i++) cyc(0, 1, "R6");
    // push and pop together
    do_reset();
    cyc(1, 0, "R7");
    cyc(1, 1, "R7");
    cyc(1, 1, "R7");
    cyc(0, 1, "R7");
    cyc(0, 1, "R7");
    cyc(0, 1, "R7");
    // idle holds
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      held = pop_addr_o;
      @(negedge clk_i);
      chk("R8 idle", pop_addr_o, held);
    end
    // all strobe combinations, pseudo-random order
    for (int i = 0; i < 400; i++) begin
      int r;
      r = (i * 7 + i / 5) % 4;
      cyc(r[0], r[1], "R4/R7 mix");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule